// File: doc/BRIEF.md
# Ripple Bit-Slice ALU with Signed Compare

This block is a purely combinational 32-bit arithmetic-logic unit. It is built from one repeated single-bit cell that is instantiated once per bit position. Each cell forms the AND and the OR of its operand bits and a full-adder sum. It also takes a carry from the cell below and a "less" input. A 2-bit selector then picks one of these four values as the cell's result bit. A shared invert line complements every bit of the B operand. The same line injects a carry of 1 into bit 0, so one chain of adders performs both addition and two's-complement subtraction.

The signed comparison is formed inside the chain itself, not by a separate comparator. The top cell subtracts and corrects its sum bit with the signed-overflow condition. The corrected bit is fed back to the "less" input of bit 0, and every other cell has its "less" input tied low. A compare therefore yields 0 or 1 in the lowest result bit.

The surrounding datapath drives the two operands and a 3-bit control word. In the same evaluation it reads the result together with the carry, overflow and zero indications. The block holds no state.

Top module: `bitslice_alu`

## Requirements
- R1: Control 3'b000 gives result = A AND B.
- R2: Control 3'b001 gives result = A OR B.
- R3: Control 3'b010 gives result = (A + B) mod 2^32, with carry_out equal to bit 32 of the unbounded sum.
- R4: Control 3'b110 gives result = (A - B) mod 2^32, with carry_out = 1 exactly when A >= B as unsigned numbers.
- R5: Control 3'b111 gives result bit 0 = 1 exactly when A < B as signed two's-complement numbers, with bits 31..1 at 0. This holds even when A - B overflows.
- R6: overflow is 1 only when control bits [1:0] are 2'b10 (sum selected) and the two adder inputs (A and the possibly inverted B) share a sign that differs from the sign of the sum. For every other control value it is 0.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: For the logic and compare codes, carry_out still equals bit 32 of A + B' + cin. Here B' is B inverted when control bit 2 is set, and cin is control bit 2.
- R9: Control bit 2 also inverts B for the logic selections: 3'b100 gives A AND NOT B, and 3'b101 gives A OR NOT B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_ctrl | input | 3 | Bit 2 inverts B and sets carry-in; bits 1:0 select AND/OR/sum/less |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Carry out of the top cell |
| overflow | output | 1 | Signed overflow for add/subtract |
| zero | output | 1 | Result is all zeros |

## Verification
On a compare, the top-cell subtraction can overflow in the same evaluation that produces the less-than bit. That bit is only right if the overflow correction is applied before the sign is fed back to bit 0. The bench provokes this with operand pairs near the signed extremes, such as the most negative value against small positives and the most positive value against negatives. These are mixed in among random pairs. Each result is judged against a signed comparison computed directly in the bench, and the overflow output is checked to stay low for the compare code.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Result selector inside each bit cell
    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } cell_sel_e;

    // Control word: invert flag on top, selector below
    typedef struct packed {
        logic      b_inv;
        cell_sel_e sel;
    } alu_ctrl_t;

    localparam logic [2:0] CTRL_AND  = 3'b000;
    localparam logic [2:0] CTRL_OR   = 3'b001;
    localparam logic [2:0] CTRL_ADD  = 3'b010;
    localparam logic [2:0] CTRL_SUB  = 3'b110;
    localparam logic [2:0] CTRL_SLT  = 3'b111;

    function automatic alu_ctrl_t decode_ctrl(input logic [2:0] raw);
        alu_ctrl_t c;
        c.b_inv = raw[2];
        c.sel   = cell_sel_e'(raw[1:0]);
        return c;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic logic par3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

endpackage

// File: rtl/alu_cell.sv
module alu_cell
    import alu_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      cin,
    input  logic      less,
    input  alu_ctrl_t ctrl,
    output logic      res,
    output logic      cout
);
    logic b_eff;
    logic sum;

    always_comb begin
        b_eff = ctrl.b_inv ? ~b : b;
        sum   = par3(a, b_eff, cin);
        cout  = maj3(a, b_eff, cin);
        unique case (ctrl.sel)
            SEL_AND:  res = a & b_eff;
            SEL_OR:   res = a | b_eff;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_top_cell.sv
module alu_top_cell
    import alu_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      cin,
    input  logic      less,
    input  alu_ctrl_t ctrl,
    output logic      res,
    output logic      cout,
    output logic      set_bit,
    output logic      ovf_raw
);
    logic core_cout;
    logic top_sum;

    alu_cell u_core (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .less (less),
        .ctrl (ctrl),
        .res  (res),
        .cout (core_cout)
    );

    always_comb begin
        top_sum = par3(a, ctrl.b_inv ? ~b : b, cin);
        cout    = core_cout;
        // carry into the top cell differing from carry out of it
        ovf_raw = cin ^ core_cout;
        // sign corrected for overflow
        set_bit = top_sum ^ ovf_raw;
    end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf_raw
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0] carry;
    logic           set_fb;

    assign carry[0] = ctrl.b_inv;
    assign cout     = carry[WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == TOP) begin : g_top
            alu_top_cell u_cell (
                .a       (a[i]),
                .b       (b[i]),
                .cin     (carry[i]),
                .less    (1'b0),
                .ctrl    (ctrl),
                .res     (res[i]),
                .cout    (carry[i+1]),
                .set_bit (set_fb),
                .ovf_raw (ovf_raw)
            );
        end else if (i == 0) begin : g_lsb
            alu_cell u_cell (
                .a    (a[i]),
                .b    (b[i]),
                .cin  (carry[i]),
                .less (set_fb),
                .ctrl (ctrl),
                .res  (res[i]),
                .cout (carry[i+1])
            );
        end else begin : g_mid
            alu_cell u_cell (
                .a    (a[i]),
                .b    (b[i]),
                .cin  (carry[i]),
                .less (1'b0),
                .ctrl (ctrl),
                .res  (res[i]),
                .cout (carry[i+1])
            );
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  alu_ctrl_t        ctrl,
    input  logic             ovf_raw,
    output logic             overflow,
    output logic             zero
);
    always_comb begin
        overflow = (ctrl.sel == SEL_SUM) ? ovf_raw : 1'b0;
        zero     = ~(|res);
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       alu_ctrl,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);
    alu_ctrl_t ctrl_dec;
    logic      ovf_top;

    assign ctrl_dec = decode_ctrl(alu_ctrl);

    alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a       (opnd_a),
        .b       (opnd_b),
        .ctrl    (ctrl_dec),
        .res     (result),
        .cout    (carry_out),
        .ovf_raw (ovf_top)
    );

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res      (result),
        .ctrl     (ctrl_dec),
        .ovf_raw  (ovf_top),
        .overflow (overflow),
        .zero     (zero)
    );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       alu_ctrl,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             zero
);
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, alu_ctrl, result, carry_out, overflow, zero})) begin
            // R7
            zero_flag_chk: assert (zero == (result == '0));
            // R6
            ovf_gate_chk: assert ((alu_ctrl[1:0] == 2'b10) || !overflow);
            // R5
            slt_upper_chk: assert ((alu_ctrl != CTRL_SLT) || (result[WIDTH-1:1] == '0));
            // R5
            slt_value_chk: assert ((alu_ctrl != CTRL_SLT) ||
                                   (result[0] == ($signed(opnd_a) < $signed(opnd_b))));
            // R4
            sub_borrow_chk: assert ((alu_ctrl != CTRL_SUB) || (carry_out == (opnd_a >= opnd_b)));
            // R1
            and_value_chk: assert ((alu_ctrl != CTRL_AND) || (result == (opnd_a & opnd_b)));
        end
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_ctrl  (alu_ctrl),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .zero      (zero)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int RAND_ITER  = 1500;
    localparam int WD_LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic [2:0]   c;
    logic [W-1:0] result;
    logic         carry_out, overflow, zero;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    bitslice_alu #(.WIDTH(W)) u_dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .alu_ctrl  (c),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow),
        .zero      (zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst) begin
            cyc <= cyc + 1;
            if (cyc > WD_LIMIT) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    // Reference model built from the requirement text
    function automatic logic [W:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2:0] k);
        logic [W-1:0] yb;
        yb = k[2] ? ~y : y;
        return {1'b0, x} + {1'b0, yb} + {{W{1'b0}}, k[2]};
    endfunction

    function automatic logic ref_ovf_raw(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [2:0] k);
        logic [W-1:0] yb;
        logic [W:0]   s;
        yb = k[2] ? ~y : y;
        s  = ref_sum(x, y, k);
        return (x[W-1] == yb[W-1]) && (s[W-1] != x[W-1]);
    endfunction

    function automatic logic [W-1:0] ref_result(input logic [W-1:0] x, input logic [W-1:0] y,
                                                input logic [2:0] k);
        logic [W-1:0] yb;
        logic [W:0]   s;
        yb = k[2] ? ~y : y;
        s  = ref_sum(x, y, k);
        case (k[1:0])
            2'b00:   return x & yb;
            2'b01:   return x | yb;
            2'b10:   return s[W-1:0];
            default: return {{(W-1){1'b0}}, s[W-1] ^ ref_ovf_raw(x, y, k)};
        endcase
    endfunction

    function automatic string res_tag(input logic [2:0] k);
        case (k)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s ctrl=%b a=%h b=%h actual=%h expected=%h",
                     tag, what, c, a, b, got, exp);
        end
    endtask

    task automatic run_one(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] k);
        logic [W:0]   s;
        logic [W-1:0] er;
        @(posedge clk);
        a = x; b = y; c = k;
        @(negedge clk);
        s  = ref_sum(x, y, k);
        er = ref_result(x, y, k);
        chk(res_tag(k), "result", result, er);
        if (k == 3'b010)      chk("R3", "carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, s[W]});
        else if (k == 3'b110) chk("R4", "carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, x >= y});
        else                  chk("R8", "carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, s[W]});
        if (k == 3'b111)
            chk("R5", "signed_lt", {{(W-1){1'b0}}, result[0]},
                {{(W-1){1'b0}}, $signed(x) < $signed(y)});
        chk("R6", "overflow", {{(W-1){1'b0}}, overflow},
            {{(W-1){1'b0}}, (k[1:0] == 2'b10) && ref_ovf_raw(x, y, k)});
        chk("R7", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, er == '0});
    endtask

    logic [W-1:0] corner [8];
    logic [2:0]   codes  [7];

    initial begin
        logic [31:0] seed_dummy;
        corner = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                   32'h7FFF_FFFF, 32'h0000_0006, 32'hFFFF_FFF9, 32'h8000_0001};
        codes  = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b100, 3'b101};
        seed_dummy = $urandom(32'd12345);
        a = '0; b = '0; c = 3'b000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state: AND of zeros
        chk("R1", "idle_result", result, '0);
        chk("R7", "idle_zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

        // directed: overflowing compares (negative minus positive, positive minus negative)
        run_one(32'h8000_0000, 32'h0000_0001, 3'b111);  // R5: true, sub overflows
        run_one(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);  // R5: false, sub overflows
        run_one(32'hFFFF_FFF9, 32'h0000_0006, 3'b111);  // R5
        run_one(32'h0000_0005, 32'h0000_0006, 3'b111);  // R5 no overflow
        run_one(32'h1234_5678, 32'h1234_5678, 3'b110);  // R4 and R7: equal -> zero
        run_one(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);  // R3 and R6: add overflow
        run_one(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);  // R3 carry, zero

        // corner grid
        foreach (codes[ci])
            foreach (corner[i])
                foreach (corner[j])
                    run_one(corner[i], corner[j], codes[ci]);

        // constrained random, some operands pulled from corners
        foreach (codes[ci]) begin
            for (int n = 0; n < RAND_ITER; n++) begin
                logic [W-1:0] x, y;
                x = $urandom;
                y = $urandom;
                if (($urandom % 5) == 0) x = corner[$urandom % 8];
                if (($urandom % 5) == 0) y = corner[$urandom % 8];
                if (($urandom % 9) == 0) y = x;
                run_one(x, y, codes[ci]);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule